// File: doc/BRIEF.md
# DAC Conversion Sequencing Controller

This block is the digital front end of a single digital-to-analog channel. Software reaches it through a small APB-style register bus. It writes sample data and configuration over that bus, and it chooses where conversion starts come from. The choices are a self-clearing software trigger, an external pin, four timer pulses and two PWM pulses. The pin can be qualified by level or by edge. When trigger mode is off, a write to the holding register starts a conversion on its own.

Each accepted start copies the holding word into a 12-bit output code. The copy is realigned first, from left- or right-justified data, and from 12-bit or 8-bit data. A settling counter then runs, and the channel stays busy until that counter reaches the programmed value. Completion raises a finish flag and an optional interrupt. In DMA mode it also raises a request for fresh data. A start that consumes data the DMA has not refreshed sets an underrun flag.

Top module: `dac_seq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, and dac_code, irq, dma_req, dac_enable and buffer_off are all 0.
- R2: With 12-bit width (control bits 15:14 = 00), the output code is set at start as follows. When right-aligned (control bit 10 = 0) it takes holding bits 11:0 and ignores bits 15:12. When left-aligned (bit 10 = 1) it takes holding bits 15:4 and ignores bits 3:0.
- R3: With 8-bit width (code 01), the byte is taken from holding bits 7:0 when right-aligned and from bits 15:8 when left-aligned. The byte goes to code bits 11:4, and bits 3:0 are 0. Width codes 10 and 11 behave like code 00.
- R4: With enable (control bit 0) set and trigger mode (bit 4) clear, a write to the holding register (0x08) starts a conversion on the next clock edge. The output code changes only at a start.
- R5: Writing 1 to bit 0 of 0x04 gives one start when trigger mode is on and the source select (control bits 7:5) is 0. The register always reads 0.
- R6: Source select 2 to 5 starts on timer pulse 0 to 3, and 6 and 7 start on PWM pulse 0 and 1. Pulses from sources that are not selected are ignored.
- R7: Source select 1 uses the external pin, qualified by control bits 13:12. The codes are 00 for low level, 01 for high level, 10 for a falling edge and 11 for a rising edge.
- R8: Busy (status bit 8) is high for the settling value (0x14, bits 9:0) plus one clocks. Finish (status bit 0) sets in the clock after busy ends.
- R9: Finish clears when a new conversion starts, and also when 1 is written to status bit 0.
- R10: A trigger that arrives while busy is ignored. A level-qualified pin that is still active starts the next conversion in the clock after finish.
- R11: With DMA mode (control bit 2) set, dma_req rises at completion and drops on a holding write. A start with no holding write since the previous start sets underrun (status bit 1). Only writing 1 to status bit 1 clears underrun.
- R12: irq is high exactly when (finish and control bit 1) or (underrun and control bit 3).
- R13: With enable clear, no conversion starts. dac_enable follows control bit 0 and buffer_off follows control bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address (0x00 control, 0x04 soft trigger, 0x08 holding, 0x0C output, 0x10 status, 0x14 settling) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the address |
| ext_pin | input | 1 | External trigger pin, already synchronous to clk |
| timer_trig | input | 4 | Timer trigger pulses |
| pwm_trig | input | 2 | PWM trigger pulses |
| dac_code | output | 12 | Code presented to the converter |
| dac_enable | output | 1 | Converter enable |
| buffer_off | output | 1 | Output buffer bypass |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Request for fresh holding data |

## Verification
The checks assume a bus write lasts exactly one cycle with psel, penable and pwrite all high. They also assume ext_pin, timer_trig and pwm_trig already change in step with clk. The bench drives every input on the falling edge and holds each write for a single cycle. This means the start edge that each property reasons about can be traced to one bus or trigger event. The underrun property also assumes that nothing but a bus write to status clears the flag. The stimulus respects this by never pulsing reset after the opening sequence.

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int SETTLE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              ext_pin,
  input  logic [3:0]        timer_trig,
  input  logic [1:0]        pwm_trig,
  output logic [11:0]       dac_code,
  output logic              dac_enable,
  output logic              buffer_off,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_SWT  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(6'h14);
  localparam logic [15:0] CTRL_MASK = 16'hF5FF;

  logic [15:0]         ctrl_q, hold_q;
  logic [11:0]         dout_q;
  logic [SETTLE_W-1:0] settle_q, cnt_q;
  logic busy_q, fin_q, udr_q, fresh_q, dreq_q, sw_q, dpend_q, pin_q;

  logic       en, ien, dmaen, urien, trgen, lalign;
  logic [2:0] tsel;
  logic [1:0] pmode, bw;
  assign en     = ctrl_q[0];
  assign ien    = ctrl_q[1];
  assign dmaen  = ctrl_q[2];
  assign urien  = ctrl_q[3];
  assign trgen  = ctrl_q[4];
  assign tsel   = ctrl_q[7:5];
  assign lalign = ctrl_q[10];
  assign pmode  = ctrl_q[13:12];
  assign bw     = ctrl_q[15:14];

  logic wr, wr_ctrl, wr_swt, wr_hold, wr_stat, wr_set;
  assign wr      = psel & penable & pwrite;
  assign wr_ctrl = wr && paddr == A_CTRL;
  assign wr_swt  = wr && paddr == A_SWT;
  assign wr_hold = wr && paddr == A_HOLD;
  assign wr_stat = wr && paddr == A_STAT;
  assign wr_set  = wr && paddr == A_SET;

  logic pin_hit, src_hit, trig, start, done;
  logic [11:0] aligned;

  always_comb begin
    case (pmode)
      2'b00:   pin_hit = ~ext_pin;
      2'b01:   pin_hit = ext_pin;
      2'b10:   pin_hit = pin_q & ~ext_pin;
      default: pin_hit = ~pin_q & ext_pin;
    endcase
  end

  always_comb begin
    case (tsel)
      3'd0:    src_hit = sw_q;
      3'd1:    src_hit = pin_hit;
      3'd2:    src_hit = timer_trig[0];
      3'd3:    src_hit = timer_trig[1];
      3'd4:    src_hit = timer_trig[2];
      3'd5:    src_hit = timer_trig[3];
      3'd6:    src_hit = pwm_trig[0];
      default: src_hit = pwm_trig[1];
    endcase
  end

  always_comb begin
    if (bw == 2'b01)
      aligned = {(lalign ? hold_q[15:8] : hold_q[7:0]), 4'h0};
    else
      aligned = lalign ? hold_q[15:4] : hold_q[11:0];
  end

  assign trig  = trgen ? src_hit : dpend_q;
  assign start = en & trig & ~busy_q;
  assign done  = busy_q && cnt_q == settle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hold_q   <= '0;
      settle_q <= '0;
      pin_q    <= 1'b0;
      sw_q     <= 1'b0;
      dpend_q  <= 1'b0;
    end else begin
      pin_q   <= ext_pin;
      sw_q    <= wr_swt & pwdata[0];
      dpend_q <= wr_hold & ~trgen;
      if (wr_ctrl) ctrl_q   <= pwdata[15:0] & CTRL_MASK;
      if (wr_hold) hold_q   <= pwdata[15:0];
      if (wr_set)  settle_q <= pwdata[SETTLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      dout_q <= aligned;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q   <= 1'b0;
      udr_q   <= 1'b0;
      fresh_q <= 1'b0;
      dreq_q  <= 1'b0;
    end else begin
      if (start)                      fin_q <= 1'b0;
      else if (done)                  fin_q <= 1'b1;
      else if (wr_stat && pwdata[0])  fin_q <= 1'b0;

      if (start && dmaen && !fresh_q) udr_q <= 1'b1;
      else if (wr_stat && pwdata[1])  udr_q <= 1'b0;

      if (wr_hold)    fresh_q <= 1'b1;
      else if (start) fresh_q <= 1'b0;

      if (done && dmaen) dreq_q <= 1'b1;
      else if (wr_hold)  dreq_q <= 1'b0;
    end
  end

  always_comb begin
    case (paddr)
      A_CTRL:  prdata = {16'h0, ctrl_q};
      A_HOLD:  prdata = {16'h0, hold_q};
      A_OUT:   prdata = {20'h0, dout_q};
      A_STAT:  prdata = {23'h0, busy_q, 6'h0, udr_q, fin_q};
      A_SET:   prdata = {{(32-SETTLE_W){1'b0}}, settle_q};
      default: prdata = '0;
    endcase
  end

  assign dac_code   = dout_q;
  assign dac_enable = en;
  assign buffer_off = ctrl_q[8];
  assign dma_req    = dreq_q;
  assign irq        = (fin_q & ien) | (udr_q & urien);
endmodule

// File: rtl/dac_seq_ctrl_chk.sv
module dac_seq_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              fin,
  input logic              udr,
  input logic              irq,
  input logic              wr,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic [11:0]       dac_code
);
  localparam logic [ADDR_W-1:0] A_SWT  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h10);

  assert_code_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(dac_code));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !fin));

  assert_fin_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $past(busy));

  assert_swt_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr == A_SWT) |-> (prdata == 32'h0));

  assert_udr_clear_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(udr) |-> $past(wr && paddr == A_STAT && pwdata[1]));

  assert_irq_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fin || udr));
endmodule

bind dac_seq_ctrl dac_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .fin(fin_q),
  .udr(udr_q), .irq(irq), .wr(wr), .paddr(paddr), .pwdata(pwdata),
  .prdata(prdata), .dac_code(dac_code)
);

// File: tb/dac_seq_ctrl_test.sv
module dac_seq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [5:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic ext_pin = 0;
  logic [3:0] timer_trig = '0;
  logic [1:0] pwm_trig = '0;
  logic [11:0] dac_code;
  logic dac_enable, buffer_off, irq, dma_req;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dac_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_pin(ext_pin),
    .timer_trig(timer_trig), .pwm_trig(pwm_trig), .dac_code(dac_code),
    .dac_enable(dac_enable), .buffer_off(buffer_off), .irq(irq), .dma_req(dma_req)
  );

  localparam logic [5:0] CTRL = 6'h00, SWT = 6'h04, HOLD = 6'h08,
                         OUTR = 6'h0C, STAT = 6'h10, SETR = 6'h14;

  // {control, holding word, expected code}
  localparam logic [43:0] VEC [6] = '{
    {16'h0001, 16'hFABC, 12'hABC},
    {16'h0401, 16'hABCF, 12'hABC},
    {16'h4001, 16'h12A5, 12'hA50},
    {16'h4401, 16'hC35A, 12'hC30},
    {16'h8001, 16'h1234, 12'h234},
    {16'hC401, 16'h5678, 12'h567}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    ticks(1);
    for (int i = 0; i < 3000; i++) begin
      rd(STAT, s);
      if (!s[8]) break;
      ticks(1);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [11:0] prev;
    int nb;
    ticks(4);
    rst_n = 1;
    ticks(1);

    // R1 reset state
    rd(CTRL, r); chk("R1 ctrl", r, 0);
    rd(HOLD, r); chk("R1 hold", r, 0);
    rd(OUTR, r); chk("R1 out", r, 0);
    rd(STAT, r); chk("R1 stat", r, 0);
    rd(SETR, r); chk("R1 settle", r, 0);
    chk("R1 pins", {dac_code, irq, dma_req, dac_enable, buffer_off}, 0);

    // R2 R3 R4 alignment table
    prev = 12'h0;
    for (int i = 0; i < 6; i++) begin
      wr(CTRL, {16'h0, VEC[i][43:28]});
      wr(HOLD, {16'h0, VEC[i][27:12]});
      chk("R4 code before start", dac_code, prev);
      ticks(1);
      chk(i < 2 ? "R2 align" : "R3 width", dac_code, VEC[i][11:0]);
      rd(OUTR, r); chk("R2 out reg", r, {20'h0, VEC[i][11:0]});
      prev = VEC[i][11:0];
      wait_idle();
    end

    // R8 busy length and finish
    wr(SETR, 5);
    wr(CTRL, 1);
    wr(HOLD, 16'h111);
    nb = 0;
    for (int i = 0; i < 10; i++) begin
      ticks(1);
      rd(STAT, r);
      if (r[8]) nb++;
    end
    chk("R8 busy cycles", nb, 6);
    chk("R8 finish", r[0], 1);
    // R9 clear by write and by new start
    wr(STAT, 1);
    rd(STAT, r); chk("R9 write-1 clear", r[0], 0);
    wr(HOLD, 16'h112);
    wait_idle();
    rd(STAT, r); chk("R9 finish set", r[0], 1);
    wr(HOLD, 16'h113);
    ticks(1);
    rd(STAT, r); chk("R9 start clears finish", r[8:0], 9'h100);
    wait_idle();

    // R12 interrupt from finish
    wr(SETR, 0);
    wr(CTRL, 3);
    wr(HOLD, 16'h114);
    wait_idle();
    chk("R12 irq finish", irq, 1);
    wr(STAT, 1);
    chk("R12 irq cleared", irq, 0);

    // R13 disabled
    wr(CTRL, 16'h0100);
    chk("R13 enable/bypass", {dac_enable, buffer_off}, 2'b01);
    wr(HOLD, 16'h777);
    ticks(3);
    chk("R13 no start", dac_code, 12'h114);

    // R5 software trigger
    wr(CTRL, 16'h11);
    wr(HOLD, 16'h222);
    ticks(2);
    chk("R5 no start without trigger", dac_code, 12'h114);
    wr(SWT, 1);
    rd(SWT, r); chk("R5 reads zero", r, 0);
    ticks(1);
    chk("R5 sw start", dac_code, 12'h222);
    wait_idle();

    // R10 trigger while busy ignored
    wr(SETR, 20);
    wr(HOLD, 16'h301);
    wr(SWT, 1);
    ticks(3);
    wr(HOLD, 16'h302);
    wr(SWT, 1);
    ticks(2);
    chk("R10 busy ignores", dac_code, 12'h301);
    wait_idle();
    wr(SWT, 1);
    ticks(1);
    chk("R10 later start", dac_code, 12'h302);
    wait_idle();
    wr(SETR, 0);

    // R6 timer and pwm select
    wr(CTRL, 16'h71);
    wr(HOLD, 16'h444);
    timer_trig = 4'b0001; ticks(1); timer_trig = 0;
    ticks(2);
    chk("R6 other timer ignored", dac_code, 12'h302);
    timer_trig = 4'b0010; ticks(1); timer_trig = 0;
    chk("R6 timer1 start", dac_code, 12'h444);
    wait_idle();
    wr(CTRL, 16'hF1);
    wr(HOLD, 16'h555);
    pwm_trig = 2'b01; ticks(1); pwm_trig = 0;
    ticks(2);
    chk("R6 pwm0 ignored", dac_code, 12'h444);
    pwm_trig = 2'b10; ticks(1); pwm_trig = 0;
    chk("R6 pwm1 start", dac_code, 12'h555);
    wait_idle();

    // R7 external pin modes
    wr(CTRL, 16'h3031);
    wr(HOLD, 16'h601);
    ticks(3);
    chk("R7 rising idle", dac_code, 12'h555);
    ext_pin = 1; ticks(1);
    chk("R7 rising start", dac_code, 12'h601);
    wait_idle();
    wr(HOLD, 16'h602);
    ticks(3);
    chk("R7 rising no refire", dac_code, 12'h601);
    wr(CTRL, 16'h2031);
    ext_pin = 0; ticks(1);
    chk("R7 falling start", dac_code, 12'h602);
    wait_idle();
    wr(SETR, 3);
    wr(CTRL, 16'h1031);
    wr(HOLD, 16'h603);
    ticks(3);
    chk("R7 high idle", dac_code, 12'h602);
    ext_pin = 1; ticks(1);
    chk("R7 high start", dac_code, 12'h603);
    for (int i = 0; i < 20; i++) begin
      rd(STAT, r);
      if (r[0]) break;
      ticks(1);
    end
    ticks(1);
    rd(STAT, r); chk("R10 level retrigger", r[8:0], 9'h100);
    ext_pin = 0;
    wait_idle();
    wr(HOLD, 16'h604);
    wr(CTRL, 16'h0031);
    ticks(1);
    chk("R7 low start", dac_code, 12'h604);
    ext_pin = 1;
    wait_idle();
    wr(SETR, 0);

    // R11 DMA request and underrun
    wr(STAT, 3);
    wr(CTRL, 16'h1D);
    wr(HOLD, 16'h701);
    wr(SWT, 1);
    wait_idle();
    chk("R11 dma_req set", dma_req, 1);
    rd(STAT, r); chk("R11 no underrun", r[1], 0);
    wr(HOLD, 16'h702);
    chk("R11 dma_req cleared", dma_req, 0);
    wr(SWT, 1);
    wait_idle();
    wr(SWT, 1);
    ticks(2);
    rd(STAT, r); chk("R11 underrun set", r[1], 1);
    chk("R12 irq underrun", irq, 1);
    wr(STAT, 1);
    rd(STAT, r); chk("R11 underrun holds", r[1], 1);
    wr(STAT, 2);
    rd(STAT, r); chk("R11 underrun cleared", r[1], 0);
    chk("R12 irq low", irq, 0);

    summary();
  end
endmodule